// File: doc/BRIEF.md
# HDLC Frame Receiver with Address Filter

This block receives one serial data channel and turns it into bytes for a receive FIFO. Each received bit comes in on `bitIn` in a cycle where `bitValid` is high. In framed mode the block finds the frames between flag octets, removes the zeros the sender inserted after runs of ones, and checks the frame check sequence. It keeps only frames whose first byte matches a programmed station address or the all-stations value. For each kept frame it writes the data bytes and then one end-of-frame status that carries a CRC-good bit and an abort bit.

In bypass mode all of this is switched off. The block packs every eight sampled bits into a byte and writes it with no interpretation. Flag patterns are stored as ordinary data. The FIFO storage and the host side are outside the block: it only drives a byte write strobe and a status strobe.

A frame's bytes are held back in a three-byte window. A byte is written once three further bytes of the same frame have arrived, and the oldest held byte is flushed at the closing flag. The two check bytes are therefore never written, and a frame too short to be valid never reaches the FIFO.

Top module: `hdlc_rx_filter`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `wrEn`, `statValid`, `statCrcOk` and `statAbort` are 0.
- R2: In framed mode (`bypass`=0), the flag octet 0,1,1,1,1,1,1,0 (in arrival order) opens and closes frames and is never written. A run of back-to-back flags produces no write and no status. Data bits arrive least significant bit first.
- R3: In framed mode, a 0 that arrives right after five consecutive 1s is removed from the data. The bytes written equal the bytes before zero insertion.
- R4: The first byte after the opening flag is the address. If it differs from `ownAddr` and is not FFh, the frame produces no write and no status.
- R5: A frame whose address byte is FFh is stored whatever the value of `ownAddr`.
- R6: The check is the reflected CRC-16 with polynomial 1021h and initial value FFFFh. The sender appends its complement, low byte first. A stored frame whose register ends at F0B8h reports `statCrcOk`=1; any other frame reports 0 but its data bytes are still written. The two check bytes are never written.
- R7: Seven consecutive 1s inside a frame with a matching address abort it. One status is written with `statAbort`=1 and `statCrcOk`=0, and no further bytes of that frame are written. Bytes already written are a prefix of the frame. The receiver then waits for the next flag.
- R8: A frame of fewer than 4 bytes between flags, check bytes included, produces no write and no status.
- R9: In bypass mode (`bypass`=1), each group of eight sampled bits forms one byte, least significant bit first, and is written. Flag patterns are written as data, and no status is ever produced.
- R10: Every write and every status appears in the cycle right after a cycle with `bitValid` high. At a closing flag, the last data byte and the status appear in the same cycle, one clock after the flag's final bit is sampled.
- R11: A change of `bypass` restarts the receiver. A partly collected byte is dropped, bits sampled in that same cycle are ignored, and framed mode starts out waiting for a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitIn | input | 1 | Serial received bit |
| bitValid | input | 1 | High in cycles where `bitIn` carries a bit |
| bypass | input | 1 | 1 selects raw byte capture, 0 selects framed mode |
| ownAddr | input | 8 | Station address that frames are compared with |
| wrData | output | 8 | Byte for the receive FIFO |
| wrEn | output | 1 | Write strobe for `wrData` |
| statValid | output | 1 | End-of-frame status strobe |
| statCrcOk | output | 1 | Frame check sequence correct (valid with `statValid`) |
| statAbort | output | 1 | Frame ended by an abort sequence (valid with `statValid`) |

## Verification
The assertions check, on every cycle, the output properties that need no knowledge of frame contents. These are the reset state, that writes and statuses only follow a sampled bit, that a good end status always comes with the final data byte, that an aborted status never claims a good CRC, and that bypass mode emits no status. Only the bench scenarios can show the rest. That covers address filtering against the programmed and broadcast values, zero removal, the CRC verdict on clean and corrupted frames, dropping of the check bytes and of short frames, and the prefix left by an abort. It also covers the byte order in bypass mode and the restart on a mode change. The bench checks these by sweeping addresses and payload lengths and comparing against byte lists and check sums it computes itself.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic restart;   // clear bit counter and CRC (flag or mode change)
    logic push;      // shift a destuffed bit into the delay line
    logic emit;      // move one bit into the byte assembler
    logic wrByte;    // write a byte to the FIFO next cycle
    logic endFrame;  // good-close status
    logic endAbort;  // abort status
  } rxCtl_t;

endpackage

// File: rtl/hdlc_rx_dpath.sv
module hdlc_rx_dpath
  import hdlc_rx_pkg::*;
#(
  parameter int               BYTE_W    = 8,
  parameter int               DLY       = 7,
  parameter int               HOLD      = 3,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD  = 16'hF0B8,
  parameter logic [BYTE_W-1:0] BCAST    = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bypass,
  input  logic [BYTE_W-1:0] ownAddr,
  input  rxCtl_t            ctl,
  output logic              byteReady,
  output logic              addrHit,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrEn,
  output logic              statValid,
  output logic              statCrcOk,
  output logic              statAbort
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [DLY-1:0]    dlyLine;
  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [CRC_W-1:0]  crc;
  logic [BYTE_W-1:0] hold [HOLD];

  logic              srcBit;
  logic [BYTE_W-1:0] newByte;
  logic [CRC_W-1:0]  crcNext;
  logic              aligned;

  always_comb begin
    srcBit    = bypass ? bitIn : dlyLine[DLY-1];
    newByte   = {srcBit, shReg[BYTE_W-1:1]};
    byteReady = ctl.emit && (bitCnt == LAST_BIT);
    addrHit   = (newByte == ownAddr) || (newByte == BCAST);
    crcNext   = (crc >> 1) ^ ((crc[0] ^ srcBit) ? CRC_POLY : '0);
    aligned   = (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyLine <= '0;
      shReg   <= '0;
      bitCnt  <= '0;
      crc     <= CRC_INIT;
      for (int i = 0; i < HOLD; i++) hold[i] <= '0;
    end else begin
      if (ctl.push) dlyLine <= {dlyLine[DLY-2:0], bitIn};
      if (ctl.restart) begin
        bitCnt <= '0;
        crc    <= CRC_INIT;
      end else if (ctl.emit) begin
        shReg  <= newByte;
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        crc    <= crcNext;
        if (byteReady && !bypass) begin
          for (int i = HOLD - 1; i > 0; i--) hold[i] <= hold[i-1];
          hold[0] <= newByte;
        end
      end
    end
  end

  // registered FIFO-side outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrData    <= '0;
      wrEn      <= 1'b0;
      statValid <= 1'b0;
      statCrcOk <= 1'b0;
      statAbort <= 1'b0;
    end else begin
      wrEn      <= ctl.wrByte;
      wrData    <= bypass ? newByte : hold[HOLD-1];
      statValid <= ctl.endFrame || ctl.endAbort;
      statCrcOk <= ctl.endFrame && (crc == CRC_GOOD) && aligned;
      statAbort <= ctl.endAbort;
    end
  end

endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int DLY  = 7,
  parameter int HOLD = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitIn,
  input  logic   bitValid,
  input  logic   bypass,
  input  logic   byteReady,
  input  logic   addrHit,
  output rxCtl_t ctl
);

  localparam int MIN_LEN = HOLD + 1;
  localparam int CNT_W   = $clog2(MIN_LEN + 1);
  localparam int FILL_W  = $clog2(DLY + 1);
  localparam int ONES_W  = 3;
  localparam logic [CNT_W-1:0]  HOLD_C   = CNT_W'(HOLD);
  localparam logic [CNT_W-1:0]  MIN_C    = CNT_W'(MIN_LEN);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DLY);
  localparam logic [ONES_W-1:0] STUFF_AT = 3'd5;
  localparam logic [ONES_W-1:0] FLAG_AT  = 3'd6;
  localparam logic [ONES_W-1:0] SAT_AT   = 3'd7;

  logic              bypassQ;
  logic              inFrame;
  logic              match;
  logic [ONES_W-1:0] ones;
  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0]  byteCnt;

  logic modeChg, framedBit, isFlag, isAbort, pushBit, endOk;

  always_comb begin
    modeChg   = bypass ^ bypassQ;
    framedBit = bitValid && !bypass && !modeChg;
    isFlag    = framedBit && !bitIn && (ones == FLAG_AT);
    isAbort   = framedBit &&  bitIn && (ones == FLAG_AT);
    pushBit   = framedBit && (bitIn ? (ones < FLAG_AT) : (ones < STUFF_AT));
    endOk     = isFlag && inFrame && match && (byteCnt >= MIN_C);

    ctl          = '0;
    ctl.restart  = modeChg || isFlag;
    ctl.push     = pushBit;
    ctl.emit     = (pushBit && inFrame && (fill == FILL_MAX)) ||
                   (bitValid && bypass && !modeChg);
    ctl.wrByte   = bypass ? byteReady
                          : ((byteReady && match && (byteCnt >= HOLD_C)) || endOk);
    ctl.endFrame = endOk;
    ctl.endAbort = isAbort && inFrame && match;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bypassQ <= 1'b0;
      inFrame <= 1'b0;
      match   <= 1'b0;
      ones    <= '0;
      fill    <= '0;
      byteCnt <= '0;
    end else if (modeChg) begin
      bypassQ <= bypass;
      inFrame <= 1'b0;
      match   <= 1'b0;
      ones    <= '0;
      fill    <= '0;
      byteCnt <= '0;
    end else if (framedBit) begin
      ones <= bitIn ? ((ones == SAT_AT) ? ones : ones + 1'b1) : '0;
      if (isFlag) begin
        inFrame <= 1'b1;
        fill    <= '0;
        byteCnt <= '0;
        match   <= 1'b0;
      end else if (isAbort) begin
        inFrame <= 1'b0;
        byteCnt <= '0;
        match   <= 1'b0;
      end else if (pushBit) begin
        if (fill != FILL_MAX) fill <= fill + 1'b1;
        if (byteReady) begin
          if (byteCnt != MIN_C) byteCnt <= byteCnt + 1'b1;
          if (byteCnt == '0) match <= addrHit;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              bypass,
  input  logic [BYTE_W-1:0] ownAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrEn,
  output logic              statValid,
  output logic              statCrcOk,
  output logic              statAbort
);

  // bits pushed before a flag is recognised: its leading 0 and six 1s
  localparam int FLAG_DLY = 7;
  localparam int HOLD     = FCS_BYTES + 1;

  rxCtl_t ctl;
  logic   byteReady;
  logic   addrHit;

  hdlc_rx_ctrl #(.DLY(FLAG_DLY), .HOLD(HOLD)) ctrlU (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .bypass    (bypass),
    .byteReady (byteReady),
    .addrHit   (addrHit),
    .ctl       (ctl)
  );

  hdlc_rx_dpath #(.BYTE_W(BYTE_W), .DLY(FLAG_DLY), .HOLD(HOLD)) dpathU (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bypass    (bypass),
    .ownAddr   (ownAddr),
    .ctl       (ctl),
    .byteReady (byteReady),
    .addrHit   (addrHit),
    .wrData    (wrData),
    .wrEn      (wrEn),
    .statValid (statValid),
    .statCrcOk (statCrcOk),
    .statAbort (statAbort)
  );

endmodule

// File: rtl/hdlc_rx_filter_chk.sv
module hdlc_rx_filter_chk (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic bypass,
  input logic wrEn,
  input logic statValid,
  input logic statCrcOk,
  input logic statAbort
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!wrEn && !statValid && !statCrcOk && !statAbort));

  assert_write_after_bit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || statValid) |-> $past(bitValid));

  assert_end_with_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && !statAbort) |-> wrEn);

  assert_abort_not_ok_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statAbort) |-> !statCrcOk);

  assert_bypass_no_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && $past(bypass)) |-> !statValid);

endmodule

bind hdlc_rx_filter hdlc_rx_filter_chk chkU (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .bypass    (bypass),
  .wrEn      (wrEn),
  .statValid (statValid),
  .statCrcOk (statCrcOk),
  .statAbort (statAbort)
);

// File: tb/hdlc_rx_filter_test.sv
module hdlc_rx_filter_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OWN = 8'h35;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic       bitValid = 1'b0;
  logic       bypass = 1'b0;
  logic [7:0] ownAddr = OWN;
  logic [7:0] wrData;
  logic       wrEn, statValid, statCrcOk, statAbort;

  hdlc_rx_filter uut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .bypass(bypass),
    .ownAddr(ownAddr), .wrData(wrData), .wrEn(wrEn), .statValid(statValid),
    .statCrcOk(statCrcOk), .statAbort(statAbort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nErr = 0;
  int gapCnt = 0;
  int txOnes = 0;

  logic [7:0] capData [0:63];
  int         capN = 0;
  logic [1:0] capStat [0:15];   // {abort, crcOk}
  int         stN = 0;
  logic [7:0] frm [0:15];
  int         frmLen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn && capN < 64) begin capData[capN] = wrData; capN++; end
      if (statValid && stN < 16) begin capStat[stN] = {statAbort, statCrcOk}; stN++; end
    end
  end

  task automatic clearCap();
    capN = 0;
    stN = 0;
  endtask

  task automatic sendBit(input logic b);
    bitIn = b;
    bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
    gapCnt++;
    if (gapCnt % 3 == 0) @(negedge clk);
  endtask

  task automatic sendDataBit(input logic b);
    sendBit(b);
    if (b) begin
      txOnes++;
      if (txOnes == 5) begin sendBit(1'b0); txOnes = 0; end
    end else txOnes = 0;
  endtask

  task automatic sendFlag();
    sendBit(1'b0);
    for (int k = 0; k < 6; k++) sendBit(1'b1);
    sendBit(1'b0);
    txOnes = 0;
  endtask

  task automatic sendByteStuffed(input logic [7:0] v);
    for (int k = 0; k < 8; k++) sendDataBit(v[k]);
  endtask

  task automatic sendByteRaw(input logic [7:0] v);
    for (int k = 0; k < 8; k++) sendBit(v[k]);
  endtask

  function automatic logic [15:0] crcAdd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r[0] ^ b[k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic makeFrame(input logic [7:0] addr, input int nPay, input int seed, input bit corrupt);
    logic [15:0] c;
    frm[0] = addr;
    for (int i = 1; i <= nPay; i++)
      frm[i] = (seed == 0) ? ((i % 2) ? 8'hFF : 8'h7E) : 8'((seed * 37 + i * 29 + 90) % 256);
    c = 16'hFFFF;
    for (int i = 0; i <= nPay; i++) c = crcAdd(c, frm[i]);
    c = ~c;
    frm[nPay + 1] = c[7:0];
    frm[nPay + 2] = c[15:8];
    frmLen = nPay + 3;
    if (corrupt) frm[1] = frm[1] ^ 8'h01;
  endtask

  task automatic runFrame(input logic [7:0] addr, input int nPay, input int seed,
                          input bit corrupt, input string req);
    bit hit, keep;
    clearCap();
    makeFrame(addr, nPay, seed, corrupt);
    sendFlag();
    for (int i = 0; i < frmLen; i++) sendByteStuffed(frm[i]);
    sendBit(1'b0);
    for (int k = 0; k < 6; k++) sendBit(1'b1);
    bitIn = 1'b0;
    bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
    hit  = (addr == ownAddr) || (addr == 8'hFF);
    keep = hit && (frmLen >= 4);
    chk(statValid == keep, {req, " R10 status at close"}, statValid, keep);
    chk(!keep || wrEn, {req, " R10 last byte with status"}, wrEn, 1);
    @(negedge clk);
    @(negedge clk);
    txOnes = 0;
    if (keep) begin
      chk(capN == frmLen - 2, {req, " R6 byte count"}, capN, frmLen - 2);
      for (int i = 0; i < frmLen - 2 && i < capN; i++)
        chk(capData[i] == frm[i], {req, " data"}, capData[i], frm[i]);
      chk(stN == 1, {req, " status count"}, stN, 1);
      chk(capStat[0] == {1'b0, !corrupt}, {req, " R6 crc verdict"}, capStat[0], {1'b0, !corrupt});
    end else begin
      chk(capN == 0, {req, " R4 R8 no write"}, capN, 0);
      chk(stN == 0, {req, " R4 R8 no status"}, stN, 0);
    end
  endtask

  task automatic runAbort(input logic [7:0] addr, input int m, input string req);
    bit hit;
    int lim;
    clearCap();
    makeFrame(addr, m - 1, 3, 1'b0);
    sendFlag();
    for (int i = 0; i < m; i++) sendByteStuffed(frm[i]);
    for (int k = 0; k < 7; k++) sendBit(1'b1);
    @(negedge clk);
    sendFlag();
    @(negedge clk);
    hit = (addr == ownAddr) || (addr == 8'hFF);
    lim = (m > 3) ? m - 3 : 0;
    if (hit) begin
      chk(stN == 1, {req, " R7 one status"}, stN, 1);
      chk(capStat[0] == 2'b10, {req, " R7 abort flags"}, capStat[0], 2'b10);
      chk(capN <= lim, {req, " R7 writes bounded"}, capN, lim);
      for (int i = 0; i < capN && i < 16; i++)
        chk(capData[i] == frm[i], {req, " R7 prefix"}, capData[i], frm[i]);
    end else begin
      chk(stN == 0, {req, " R7 R4 no status"}, stN, 0);
      chk(capN == 0, {req, " R7 R4 no write"}, capN, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] addrs [0:5];
    logic [7:0] raw [0:4];
    addrs[0] = OWN; addrs[1] = 8'hFF; addrs[2] = 8'h34;
    addrs[3] = 8'hB5; addrs[4] = 8'h00; addrs[5] = 8'h7E;
    raw[0] = 8'h7E; raw[1] = 8'hA5; raw[2] = 8'h00; raw[3] = 8'hFF; raw[4] = 8'h3C;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!wrEn && !statValid && !statCrcOk && !statAbort, "R1 in reset",
        {wrEn, statValid, statCrcOk, statAbort}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!wrEn && !statValid && !statCrcOk && !statAbort, "R1 after reset",
        {wrEn, statValid, statCrcOk, statAbort}, 0);

    // R2 idle flags only
    clearCap();
    for (int i = 0; i < 4; i++) sendFlag();
    @(negedge clk);
    chk(capN == 0 && stN == 0, "R2 flags not stored", capN + stN, 0);

    // R4 R5 R8 sweep of addresses and lengths
    for (int a = 0; a < 6; a++)
      for (int p = 0; p < 5; p++)
        runFrame(addrs[a], p, a * 5 + p + 1, 1'b0, "R4 R5 R8 sweep");

    // R3 stuffing-heavy payloads
    for (int p = 1; p < 6; p++) runFrame(OWN, p, 0, 1'b0, "R3 stuffing");
    runFrame(8'hFF, 4, 0, 1'b0, "R3 R5 stuffing broadcast");

    // R6 corrupted frames still stored with bad verdict
    for (int p = 1; p < 4; p++) runFrame(OWN, p, 7 + p, 1'b1, "R6 corrupt");
    runFrame(8'h12, 3, 9, 1'b1, "R6 R4 corrupt unmatched");

    // R7 aborts
    runAbort(OWN, 2, "R7 early abort");
    runAbort(8'hFF, 7, "R7 late abort");
    runAbort(8'h44, 5, "R7 unmatched abort");
    runFrame(OWN, 2, 11, 1'b0, "R7 recovery frame");

    // R9 bypass capture
    bypass = 1'b1;
    repeat (2) @(negedge clk);
    clearCap();
    for (int i = 0; i < 5; i++) sendByteRaw(raw[i]);
    @(negedge clk);
    chk(capN == 5, "R9 bypass byte count", capN, 5);
    for (int i = 0; i < 5 && i < capN; i++)
      chk(capData[i] == raw[i], "R9 bypass data", capData[i], raw[i]);
    chk(stN == 0, "R9 bypass no status", stN, 0);

    // R11 mode change drops partial byte
    clearCap();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    bypass = 1'b0;
    repeat (2) @(negedge clk);
    bypass = 1'b1;
    repeat (2) @(negedge clk);
    sendByteRaw(8'hC3);
    @(negedge clk);
    chk(capN == 1, "R11 single byte after restart", capN, 1);
    chk(capN > 0 && capData[0] == 8'hC3, "R11 restart alignment", capData[0], 8'hC3);

    // R11 back to framed mode, starts hunting
    bypass = 1'b0;
    repeat (2) @(negedge clk);
    runFrame(OWN, 3, 21, 1'b0, "R11 framed after bypass");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule